// File: doc/BRIEF.md
# Serial Channel Wakeup Event Generator

This block raises power-management wakeup requests for a function that contains several serial channels (two by default). It watches each channel's four active-low modem status lines (ring, clear-to-send, data-set-ready, carrier-detect) and its serial receive line. It decides from the function's current power state whether a line activity counts as a wakeup. In the deepest state only the end of a ring pulse counts. In the intermediate low-power state, any change on a line whose per-channel mask bit leaves it enabled counts.

A wakeup sets a sticky status bit in a 16-bit power-management control/status register. While that bit and an enable bit are both set, the block holds the active-low event output low. The output goes low in the same cycle the event is detected, with no filter. When the wakeup came from a serial receive line, the block also raises a clock-enable request for that channel. The channel clock then runs soon enough to keep framing on the arriving data, and the request stays up until software returns the function to a full-power state.

Top module: `serwake_top`

## Requirements
- R1: Each line input passes through two synchronizing flip-flops before detection. A change driven between clock edges cannot affect `pme_n` before the second following rising edge, and with the enable set it affects `pme_n` right after that edge.
- R2: With `pstate` = 2'b11 (deepest state), the only wakeup source per channel is a low-to-high transition of that channel's `ri_n`. A falling `ri_n`, and any change on the other modem lines or `sin`, raise nothing.
- R3: With `pstate` = 2'b10, a change in either direction on a channel line raises a wakeup when that line's mask bit is 0. A mask bit of 1 suppresses the line. Mask bit positions: 0 ring, 1 clear-to-send, 2 data-set-ready, 3 carrier-detect, 4 serial input. `mask_we[c]` loads `mask_wdata` into channel c's mask.
- R4: After reset the status bit and enable bit are 0, `pme_n` is 1, `clk_req` is all 0, and every mask bit is 0, so all lines are enabled in state 2'b10.
- R5: A serial-input wakeup in state 2'b10 raises `clk_req` for that channel in the same cycle `pme_n` would fall. The request stays 1 until the clock edge after `pstate` reads 2'b00 or 2'b01.
- R6: `csr_rdata` bit 15 is the status bit, bit 8 is the enable bit, and all other bits are 0. A wakeup sets bit 15. It is sticky and clears only when `csr_we` is high with `csr_wdata[15]` = 1. A write with bit 15 = 0 leaves it unchanged.
- R7: Every `csr_we` write loads the enable bit from `csr_wdata[8]`. `pme_n` is 0 whenever status and enable are both 1. Clearing the enable releases `pme_n` to 1 without clearing the status bit.
- R8: `pme_n` falls in the cycle the event is detected, one clock before the status bit reads back as 1.
- R9: With `pstate` = 2'b00 or 2'b01, no line activity raises a wakeup, and entering a low-power state afterwards does not replay that earlier activity.
- R10: Wakeups from any channel set the same single status bit.
- R11: If a clear write and a new wakeup occur on the same clock edge, the status bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pstate | input | 2 | Function power state: 00 full, 01 light, 10 intermediate, 11 deepest |
| ri_n | input | NUM_CH | Per-channel ring indicator, active low |
| cts_n | input | NUM_CH | Per-channel clear-to-send, active low |
| dsr_n | input | NUM_CH | Per-channel data-set-ready, active low |
| dcd_n | input | NUM_CH | Per-channel carrier-detect, active low |
| sin | input | NUM_CH | Per-channel serial receive line, idles high |
| mask_we | input | NUM_CH | Per-channel mask load strobe |
| mask_wdata | input | 5 | Mask value, 1 suppresses a line |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 16 | Write data: bit 15 clears status on 1, bit 8 is the enable |
| csr_rdata | output | 16 | Register readback: status at 15, enable at 8 |
| pme_n | output | 1 | Wakeup event output, active low |
| clk_req | output | NUM_CH | Per-channel clock-enable request |

## Verification
Ring pulses are applied in the deepest state in both directions, alongside toggles on the other lines. This separates trailing-edge detection from plain change detection. In the intermediate state, single-line toggles are applied on each channel with various masks. This shows whether each mask bit gates only its own line and whether either channel reaches the shared status bit. Activity in the full-power states followed by a state change tests that past edges are not replayed. A clear write placed on the exact detection edge, and enable toggles around a set status bit, separate the sticky, priority and output-release rules. A cycle model compares `pme_n`, `clk_req` and the readback on every clock.

// File: rtl/serwake_pkg.sv
package serwake_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  localparam int NUM_LINES  = 5;
  localparam int LN_RING    = 0;
  localparam int LN_CTS     = 1;
  localparam int LN_DSR     = 2;
  localparam int LN_DCD     = 3;
  localparam int LN_SIN     = 4;

  localparam int CSR_W      = 16;
  localparam int CSR_STS    = 15;
  localparam int CSR_ENA    = 8;

  typedef logic [NUM_LINES-1:0] line_vec_t;

  function automatic logic is_low_power(input logic [1:0] ps);
    return ps[1];
  endfunction

endpackage

// File: rtl/serwake_sync.sv
module serwake_sync #(
  parameter int WIDTH     = 5,
  parameter int STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  // Next-state: each stage takes the one before it.
  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[g] <= RST_VAL;
        end else begin
          stg_q[g] <= stg_d[g];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/serwake_chan.sv
module serwake_chan
  import serwake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] pstate,
  input  line_vec_t lines_in,
  input  logic      mask_we,
  input  line_vec_t mask_wdata,
  output logic      wake,
  output logic      sin_wake,
  output logic      clk_req
);

  line_vec_t line_s;
  line_vec_t prev_q, prev_d;
  line_vec_t mask_q, mask_d;
  logic      creq_q, creq_d;
  line_vec_t chg;
  line_vec_t hit;
  logic      ring_trail;

  serwake_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NUM_LINES{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (lines_in),
    .dout (line_s)
  );

  // Detection works on the synchronized value against the previous one.
  always_comb begin
    chg        = line_s ^ prev_q;
    ring_trail = line_s[LN_RING] & ~prev_q[LN_RING];
    hit        = '0;
    unique case (pstate_e'(pstate))
      PS_D3:   hit[LN_RING] = ring_trail;
      PS_D2:   hit = chg & ~mask_q;
      default: hit = '0;
    endcase
  end

  assign wake     = |hit;
  assign sin_wake = hit[LN_SIN];

  // Next-state for the history, mask and clock request registers.
  always_comb begin
    prev_d = line_s;
    mask_d = mask_q;
    if (mask_we) begin
      mask_d = mask_wdata;
    end
    creq_d = creq_q;
    if (!is_low_power(pstate)) begin
      creq_d = 1'b0;
    end else if (sin_wake) begin
      creq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      mask_q <= '0;
      creq_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      mask_q <= mask_d;
      creq_q <= creq_d;
    end
  end

  assign clk_req = creq_q | sin_wake;

endmodule

// File: rtl/serwake_csr.sv
module serwake_csr
  import serwake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_any,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic             sts_q,
  output logic             ena_q
);

  logic sts_d, ena_d;
  logic clr;

  assign clr = csr_we & csr_wdata[CSR_STS];

  always_comb begin
    sts_d = sts_q;
    if (wake_any) begin
      sts_d = 1'b1;
    end else if (clr) begin
      sts_d = 1'b0;
    end
    ena_d = ena_q;
    if (csr_we) begin
      ena_d = csr_wdata[CSR_ENA];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      ena_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      ena_q <= ena_d;
    end
  end

endmodule

// File: rtl/serwake_top.sv
module serwake_top
  import serwake_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pstate,
  input  logic [NUM_CH-1:0] ri_n,
  input  logic [NUM_CH-1:0] cts_n,
  input  logic [NUM_CH-1:0] dsr_n,
  input  logic [NUM_CH-1:0] dcd_n,
  input  logic [NUM_CH-1:0] sin,
  input  logic [NUM_CH-1:0] mask_we,
  input  logic [4:0]        mask_wdata,
  input  logic              csr_we,
  input  logic [15:0]       csr_wdata,
  output logic [15:0]       csr_rdata,
  output logic              pme_n,
  output logic [NUM_CH-1:0] clk_req
);

  logic [NUM_CH-1:0] wake_vec;
  logic [NUM_CH-1:0] sin_wake_vec;
  logic              wake_any;
  logic              sts_q, ena_q;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      line_vec_t ln;
      always_comb begin
        ln          = '1;
        ln[LN_RING] = ri_n[c];
        ln[LN_CTS]  = cts_n[c];
        ln[LN_DSR]  = dsr_n[c];
        ln[LN_DCD]  = dcd_n[c];
        ln[LN_SIN]  = sin[c];
      end

      serwake_chan #(
        .SYNC_STAGES(SYNC_STAGES)
      ) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .pstate    (pstate),
        .lines_in  (ln),
        .mask_we   (mask_we[c]),
        .mask_wdata(mask_wdata),
        .wake      (wake_vec[c]),
        .sin_wake  (sin_wake_vec[c]),
        .clk_req   (clk_req[c])
      );
    end
  endgenerate

  assign wake_any = |wake_vec;

  serwake_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_any (wake_any),
    .csr_we   (csr_we),
    .csr_wdata(csr_wdata),
    .sts_q    (sts_q),
    .ena_q    (ena_q)
  );

  // Event output follows status, or a same-cycle detection, gated by enable.
  assign pme_n = ~(ena_q & (sts_q | wake_any));

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[CSR_STS] = sts_q;
    csr_rdata[CSR_ENA] = ena_q;
  end

endmodule

// File: rtl/serwake_chk.sv
module serwake_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        pstate,
  input logic              csr_we,
  input logic [15:0]       csr_wdata,
  input logic [NUM_CH-1:0] wake_vec,
  input logic [NUM_CH-1:0] sin_wake_vec,
  input logic [NUM_CH-1:0] clk_req,
  input logic              sts_q,
  input logic              ena_q,
  input logic              pme_n
);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !(csr_we && csr_wdata[15])) |=> sts_q);

  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_vec) |=> sts_q);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_q |-> pme_n);

  a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && ena_q) |-> !pme_n);

  a_r8_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q && (|wake_vec)) |-> !pme_n);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pstate[1] |-> (wake_vec == '0));

  a_r2_no_sin_in_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'b11) |-> (sin_wake_vec == '0));

  a_r5_clk_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_wake_vec & ~clk_req) == '0);

  a_r5_clk_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pstate[1] |=> ((clk_req & ~sin_wake_vec) == '0));

endmodule

bind serwake_top serwake_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pstate      (pstate),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .wake_vec    (wake_vec),
  .sin_wake_vec(sin_wake_vec),
  .clk_req     (clk_req),
  .sts_q       (sts_q),
  .ena_q       (ena_q),
  .pme_n       (pme_n)
);

// File: tb/sim_serwake_top.sv
`timescale 1ns/1ps
module sim_serwake_top;

  localparam int NC = 2;
  localparam int NL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pstate = 2'b00;
  logic [NC-1:0] ri_n, cts_n, dsr_n, dcd_n, sin;
  logic [NC-1:0] mask_we = '0;
  logic [4:0] mask_wdata = '0;
  logic csr_we = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic [15:0] csr_rdata;
  logic pme_n;
  logic [NC-1:0] clk_req;

  bit lv [NC][NL];

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      ri_n[c]  = lv[c][0];
      cts_n[c] = lv[c][1];
      dsr_n[c] = lv[c][2];
      dcd_n[c] = lv[c][3];
      sin[c]   = lv[c][4];
    end
  end

  serwake_top u0 (
    .clk(clk), .rst_n(rst_n), .pstate(pstate),
    .ri_n(ri_n), .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .sin(sin),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .pme_n(pme_n), .clk_req(clk_req)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit s1 [NC][NL];
  bit s2 [NC][NL];
  bit pv [NC][NL];
  bit mk [NC][NL];
  bit m_sts, m_ena;
  bit m_ck [NC];

  function automatic bit ev(input int c, input int i);
    if (pstate == 2'b11) return (i == 0) && !pv[c][i] && s2[c][i];
    if (pstate == 2'b10) return !mk[c][i] && (s2[c][i] != pv[c][i]);
    return 0;
  endfunction

  function automatic bit any_ev();
    bit r = 0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NL; i++)
        if (ev(c, i)) r = 1;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_ck[c] = 0;
        for (int i = 0; i < NL; i++) begin
          s1[c][i] = 1; s2[c][i] = 1; pv[c][i] = 1; mk[c][i] = 0;
        end
      end
      m_sts = 0; m_ena = 0;
    end else begin
      bit a;
      a = any_ev();
      for (int c = 0; c < NC; c++) begin
        if (pstate < 2) m_ck[c] = 0;
        else if (ev(c, 4)) m_ck[c] = 1;
      end
      if (a) m_sts = 1;
      else if (csr_we && csr_wdata[15]) m_sts = 0;
      if (csr_we) m_ena = csr_wdata[8];
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < NL; i++) begin
          if (mask_we[c]) mk[c][i] = mask_wdata[i];
          pv[c][i] = s2[c][i];
          s2[c][i] = s1[c][i];
          s1[c][i] = lv[c][i];
        end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit ep;
      ep = !(m_ena && (m_sts || any_ev()));
      chk("R7 pme_n model", pme_n, ep);
      chk("R6 csr_rdata model", csr_rdata, {m_sts, 6'b0, m_ena, 8'b0});
      for (int c = 0; c < NC; c++)
        chk("R5 clk_req model", clk_req[c], m_ck[c] || (pstate == 2'b10 && ev(c, 4)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic nx();
    @(negedge clk);
  endtask

  task automatic smp();
    @(negedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) nx();
  endtask

  task automatic wr_csr(input logic [15:0] d);
    nx(); csr_we = 1; csr_wdata = d;
    nx(); csr_we = 0; csr_wdata = '0;
  endtask

  task automatic wr_mask(input int c, input logic [4:0] m);
    nx(); mask_we = '0; mask_we[c] = 1; mask_wdata = m;
    nx(); mask_we = '0;
  endtask

  task automatic setl(input int c, input int i, input bit v);
    nx(); lv[c][i] = v;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NL; i++) lv[c][i] = 1;
    #20;
    @(negedge clk); rst_n = 1;
    #2;
    // R4 reset state
    chk("R4 pme_n reset", pme_n, 1);
    chk("R4 csr reset", csr_rdata, 16'h0000);
    chk("R4 clk_req reset", clk_req, 0);

    // enable, deepest state
    wr_csr(16'h0100);
    chk("R7 enable readback", csr_rdata, 16'h0100);
    pstate = 2'b11;
    idle(3);
    // R2 other lines and falling ring ignored
    setl(0, 1, 0); setl(0, 4, 0); setl(0, 1, 1); setl(0, 4, 1);
    setl(0, 0, 0);
    idle(4);
    #2;
    chk("R2 no wake from non-ring or falling ring", pme_n, 1);
    chk("R2 status clear", csr_rdata, 16'h0100);
    // R1/R8 timing of trailing ring edge
    setl(0, 0, 1);
    smp(); chk("R1 not after one edge", pme_n, 1);
    smp(); chk("R8 pme_n low at detection", pme_n, 0);
    chk("R8 status not yet set", csr_rdata, 16'h0100);
    smp(); chk("R2 status set by ring trail", csr_rdata, 16'h8100);

    // R7 release without clearing status
    wr_csr(16'h0000); #2;
    chk("R7 released", pme_n, 1);
    chk("R7 status kept", csr_rdata, 16'h8000);
    wr_csr(16'h0100); #2;
    chk("R7 reasserted", pme_n, 0);
    // R6 write with bit15 = 0 keeps status, then clear
    wr_csr(16'h0100); #2;
    chk("R6 no clear without bit15", csr_rdata, 16'h8100);
    wr_csr(16'h8100); #2;
    chk("R6 cleared", csr_rdata, 16'h0100);
    chk("R6 pme_n high after clear", pme_n, 1);

    // R9 quiet in light state
    pstate = 2'b01;
    setl(1, 3, 0); setl(0, 0, 0); setl(0, 0, 1); setl(1, 4, 0);
    idle(4); #2;
    chk("R9 no wake in D1", csr_rdata, 16'h0100);
    pstate = 2'b10;
    idle(3); #2;
    chk("R9 no replay entering D2", csr_rdata, 16'h0100);
    setl(1, 4, 1);
    idle(4); #2;
    chk("R3 sin ch1 wakes with reset mask", csr_rdata, 16'h8100);
    chk("R5 clk_req ch1", clk_req, 2'b10);
    wr_csr(16'h8100);

    // R3/R10 ch1 carrier line, reset masks cleared (R4)
    setl(1, 3, 1);
    idle(4); #2;
    chk("R10 ch1 sets shared status", csr_rdata, 16'h8100);
    chk("R4 mask cleared after reset", pme_n, 0);
    wr_csr(16'h8100);

    // R3 masked line ignored, only sin enabled on ch0
    wr_mask(0, 5'b01111);
    setl(0, 1, 0); setl(0, 2, 0); setl(0, 0, 0);
    idle(4); #2;
    chk("R3 masked lines ignored", csr_rdata, 16'h0100);
    chk("R3 pme_n high when masked", pme_n, 1);
    // R5 serial input wake and clock request
    setl(0, 4, 0);
    smp(); chk("R5 clk_req not yet", clk_req[0], 0);
    smp(); chk("R5 clk_req with detection", clk_req[0], 1);
    chk("R5 pme_n same cycle", pme_n, 0);
    idle(3); #2;
    chk("R5 clk_req held", clk_req[0], 1);
    pstate = 2'b00;
    smp(); chk("R5 clk_req dropped in D0", clk_req, 0);
    wr_csr(16'h8100);

    // R11 clear and event on the same edge
    pstate = 2'b10;
    wr_mask(0, 5'b00000);
    idle(2);
    setl(0, 3, 0);
    nx();
    nx(); csr_we = 1; csr_wdata = 16'h8100;
    nx(); csr_we = 0; csr_wdata = '0;
    #2;
    chk("R11 event wins over clear", csr_rdata, 16'h8100);
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule